// File: doc/BRIEF.md
# ADC conversion control sequencer

This block is the control core that sits between software and an external analog-to-digital converter. Software reads and writes one 32-bit control and status word through a plain register port. That port has no address, only a write strobe, write data and a combinational read-back. From that word the sequencer powers the converter, powers the on-die temperature sensor, and starts conversions. It then tracks each conversion until the converter reports completion.

Conversions can be started one at a time through a self-clearing trigger bit. They can also run back to back while a level-held run bit stays set. A per-channel scan mask makes the sequencer step the channel selector through the enabled channels after every conversion. The selector field always reads back the channel that the next conversion will use.

The converter side is a start/done handshake. The sequencer raises `conv_start` for one cycle with `conv_chan` valid. It then waits for a one-cycle `conv_done`, and it samples `conv_err` in that same cycle. It never raises a second start before the done of the first, so the converter needs no back-pressure signal. A `conv_done` is accepted only while a conversion is in flight, and not in the cycle in which `conv_start` is high.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The whole word resets to 0. Bits 4-7, 11, 15 and 21-31 always read 0. Bit 8 (ready) and bit 9 (error) cannot be written.
- R2: With bit 0 (enable) = 1 and bit 3 (run) = 0 in the written value, writing 1 to bit 2 (trigger) gives exactly one `conv_start`. That start is a one-cycle pulse, and bit 2 reads 0 from the cycle in which `conv_start` is high.
- R3: A write with bit 3 = 1 discards any trigger in it, so bit 2 reads 0 in the following cycle. After run is cleared, no extra conversion appears.
- R4: While bit 3 = 1, `conv_start` is high in the cycle right after the cycle in which `conv_done` is accepted. After bit 3 is cleared, the conversion in flight still completes and no further one starts.
- R5: Bit 8 reads 1 exactly when enable is 1 and no conversion is in flight. It reads 0 from the `conv_start` cycle until the done is accepted.
- R6: Bit 9 holds the `conv_err` value sampled with the most recent accepted done.
- R7: Bit 10 (sticky error) sets on any accepted done with `conv_err` = 1. It clears only when a write has bit 10 = 1. A write with bit 10 = 0 leaves it unchanged. If an error done and a clearing write happen in the same cycle, the bit ends at 1.
- R8: Bits 14:12 (selector) drive `conv_chan`, so the first conversion uses the current selector. Bits 20:16 are the scan mask, with bit 16+i enabling channel i. When the mask is nonzero, each accepted done moves the selector to the next enabled channel in ascending order, wrapping from 4 to 0. A zero mask leaves the selector unchanged.
- R9: If the selector is not an enabled channel, the search starts at the channel above it, and a value of 4 or above restarts the search at channel 0. With one mask bit set, the selector settles and then stays on that channel.
- R10: While enable is 0, nothing starts, a trigger is dropped rather than held, bit 8 reads 0 and `conv_pwr` is 0. A conversion already in flight still completes and updates bit 9.
- R11: `conv_pwr` follows bit 0, and `conv_tsens_pwr` follows bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control and status word |
| conv_start | output | 1 | One-cycle conversion start pulse |
| conv_chan | output | 3 | Channel for the conversion (selector field) |
| conv_pwr | output | 1 | Converter power and clock enable |
| conv_tsens_pwr | output | 1 | Temperature sensor power |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_err | input | 1 | Error status, valid with `conv_done` |

## Verification
The scan table is aimed at the next-channel search:
- A selector outside the mask must not be treated as enabled.
- A selector of 6 must restart the search at channel 0.
- A one-bit mask must hold its channel instead of walking off it.
A wrong search shows up as a different channel on `conv_start` or in the read-back selector.

Run mode is checked in two ways. Each start must follow an accepted done with no gap, and clearing run must stop the sequence after the conversion in flight, so an off-by-one gap or an extra start is caught.

The sticky error bit is checked on three writes:
- a write-0, which must leave it set;
- a write-1, which must clear it;
- a clearing write that lands on the cycle of an error done, which must leave it set.

Turning enable off in mid-conversion must still let the error status of that conversion land, and must not start the conversion again.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W       = 32;
  localparam int POS_EN      = 0;
  localparam int POS_TS      = 1;
  localparam int POS_ONCE    = 2;
  localparam int POS_MANY    = 3;
  localparam int POS_RDY     = 8;
  localparam int POS_ERR     = 9;
  localparam int POS_STK     = 10;
  localparam int POS_SEL_LO  = 12;
  localparam int POS_MASK_LO = 16;
endpackage

// File: rtl/adc_seq_next_chan.sv
module adc_seq_next_chan #(
  parameter int NCH   = 5,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] cur_sel,
  input  logic [NCH-1:0]   scan_mask,
  output logic [SEL_W-1:0] nxt_sel
);
  localparam logic [SEL_W:0] NCH_W = (SEL_W+1)'(NCH);
  localparam logic [SEL_W:0] LAST  = (SEL_W+1)'(NCH - 1);

  logic [SEL_W-1:0] base;
  logic [SEL_W-1:0] cand [NCH];
  logic [NCH-1:0]   hit;

  // search begins one above the current channel; past the last channel it restarts at 0
  assign base = ({1'b0, cur_sel} >= LAST) ? '0 : cur_sel + 1'b1;

  for (genvar k = 0; k < NCH; k++) begin : g_cand
    logic [SEL_W:0] sum;
    assign sum     = {1'b0, base} + (SEL_W+1)'(k);
    assign cand[k] = (sum >= NCH_W) ? SEL_W'(sum - NCH_W) : sum[SEL_W-1:0];
    assign hit[k]  = scan_mask[cand[k]];
  end

  always_comb begin
    nxt_sel = cur_sel;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (hit[k]) nxt_sel = cand[k];
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic run_req,
  input  logic once_req,
  input  logic conv_done,
  output logic busy,
  output logic conv_start,
  output logic launch,
  output logic done_acc
);
  assign done_acc = busy & conv_done & ~conv_start;
  assign launch   = en & (run_req | once_req) & (~busy | done_acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= launch;
      if (launch)        busy <= 1'b1;
      else if (done_acc) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_err.sv
module adc_seq_err (
  input  logic clk,
  input  logic rst_n,
  input  logic done_acc,
  input  logic conv_err,
  input  logic clr_req,
  output logic err_last,
  output logic err_sticky
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_last   <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      if (done_acc) err_last <= conv_err;
      if (done_acc && conv_err) err_sticky <= 1'b1;
      else if (clr_req)         err_sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH   = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             conv_start,
  output logic [SEL_W-1:0] conv_chan,
  output logic             conv_pwr,
  output logic             conv_tsens_pwr,
  input  logic             conv_done,
  input  logic             conv_err
);
  logic             en_q, ts_q, many_q, once_q;
  logic [SEL_W-1:0] sel_q, sel_nxt;
  logic [NCH-1:0]   mask_q;
  logic             busy, launch, done_acc;
  logic             err_last, err_sticky;

  logic w_en, w_many, w_once, w_clr;
  assign w_en   = reg_wdata[POS_EN];
  assign w_many = reg_wdata[POS_MANY];
  assign w_once = reg_wdata[POS_ONCE];
  assign w_clr  = reg_we & reg_wdata[POS_STK];

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[REG_W-1:POS_MASK_LO+NCH],
                          reg_wdata[POS_MASK_LO-1:POS_SEL_LO+SEL_W],
                          reg_wdata[POS_SEL_LO-1:POS_STK+1],
                          reg_wdata[POS_STK-1:POS_MANY+1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ts_q   <= 1'b0;
      many_q <= 1'b0;
      once_q <= 1'b0;
      sel_q  <= '0;
      mask_q <= '0;
    end else begin
      if (reg_we) begin
        en_q   <= w_en;
        ts_q   <= reg_wdata[POS_TS];
        many_q <= w_many;
        mask_q <= reg_wdata[POS_MASK_LO +: NCH];
      end
      // a software write to the selector takes precedence over the scan step
      if (reg_we)                     sel_q <= reg_wdata[POS_SEL_LO +: SEL_W];
      else if (done_acc && |mask_q)   sel_q <= sel_nxt;
      // trigger: held until launched, dropped on disable or run
      if (reg_we && w_once && w_en && !w_many)       once_q <= 1'b1;
      else if (launch || (reg_we && (!w_en || w_many))) once_q <= 1'b0;
    end
  end

  adc_seq_next_chan #(.NCH(NCH), .SEL_W(SEL_W)) u_pick (
    .cur_sel   (sel_q),
    .scan_mask (mask_q),
    .nxt_sel   (sel_nxt)
  );

  adc_seq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .run_req    (many_q),
    .once_req   (once_q),
    .conv_done  (conv_done),
    .busy       (busy),
    .conv_start (conv_start),
    .launch     (launch),
    .done_acc   (done_acc)
  );

  adc_seq_err u_err (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_acc   (done_acc),
    .conv_err   (conv_err),
    .clr_req    (w_clr),
    .err_last   (err_last),
    .err_sticky (err_sticky)
  );

  always_comb begin
    reg_rdata                           = '0;
    reg_rdata[POS_EN]                   = en_q;
    reg_rdata[POS_TS]                   = ts_q;
    reg_rdata[POS_ONCE]                 = once_q;
    reg_rdata[POS_MANY]                 = many_q;
    reg_rdata[POS_RDY]                  = en_q & ~busy;
    reg_rdata[POS_ERR]                  = err_last;
    reg_rdata[POS_STK]                  = err_sticky;
    reg_rdata[POS_SEL_LO +: SEL_W]      = sel_q;
    reg_rdata[POS_MASK_LO +: NCH]       = mask_q;
  end

  assign conv_chan      = sel_q;
  assign conv_pwr       = en_q;
  assign conv_tsens_pwr = ts_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic wr_many,
  input logic wr_clr,
  input logic rd_en,
  input logic rd_once,
  input logic rd_ready,
  input logic rd_err,
  input logic rd_sticky,
  input logic conv_start,
  input logic conv_err,
  input logic busy,
  input logic done_acc
);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_once_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !$past(wr_en)) |-> !rd_once);

  p_once_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_many) |=> !rd_once);

  p_not_ready_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rd_ready);

  p_err_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> (rd_err == $past(conv_err)));

  p_sticky_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_acc && conv_err) |=> rd_sticky);

  p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_sticky) |-> $past(wr_en && wr_clr));

  p_start_enabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(rd_en));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (reg_we),
  .wr_many    (reg_wdata[adc_seq_pkg::POS_MANY]),
  .wr_clr     (reg_wdata[adc_seq_pkg::POS_STK]),
  .rd_en      (reg_rdata[adc_seq_pkg::POS_EN]),
  .rd_once    (reg_rdata[adc_seq_pkg::POS_ONCE]),
  .rd_ready   (reg_rdata[adc_seq_pkg::POS_RDY]),
  .rd_err     (reg_rdata[adc_seq_pkg::POS_ERR]),
  .rd_sticky  (reg_rdata[adc_seq_pkg::POS_STK]),
  .conv_start (conv_start),
  .conv_err   (conv_err),
  .busy       (busy),
  .done_acc   (done_acc)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        conv_start;
  logic [2:0]  conv_chan;
  logic        conv_pwr, conv_tsens_pwr;
  logic        conv_done, conv_err;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_b2b = 0;
  logic [2:0] last_chan = '0;
  logic prev_done = 1'b0;
  logic err_mode = 1'b0;
  int lat_cnt = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_pwr(conv_pwr), .conv_tsens_pwr(conv_tsens_pwr),
    .conv_done(conv_done), .conv_err(conv_err)
  );

  // fixed-latency converter model
  always @(posedge clk) begin
    if (!rst_n) begin
      conv_done <= 1'b0; conv_err <= 1'b0; lat_cnt <= 0;
    end else begin
      conv_done <= 1'b0; conv_err <= 1'b0;
      if (lat_cnt != 0) begin
        lat_cnt <= lat_cnt - 1;
        if (lat_cnt == 1) begin conv_done <= 1'b1; conv_err <= err_mode; end
      end else if (conv_start) lat_cnt <= LAT;
    end
  end

  // start monitor
  always @(posedge clk) begin
    prev_done <= conv_done;
    if (conv_start) begin
      n_start   <= n_start + 1;
      last_chan <= conv_chan;
      if (prev_done) n_b2b <= n_b2b + 1;
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic en, input logic ts, input logic once,
                                     input logic many, input logic clr,
                                     input logic [2:0] sel, input logic [4:0] mask);
    logic [31:0] v = '0;
    v[0] = en; v[1] = ts; v[2] = once; v[3] = many; v[10] = clr;
    v[14:12] = sel; v[20:16] = mask;
    return v;
  endfunction

  task automatic wr(input logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!reg_rdata[8]) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {sel, mask, chan0, chan1, chan2, chan3, final sel}
  localparam logic [22:0] RR_TAB [6] = '{
    {3'd0, 5'b11111, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4},
    {3'd3, 5'b10101, 3'd3, 3'd4, 3'd0, 3'd2, 3'd4},
    {3'd2, 5'b00100, 3'd2, 3'd2, 3'd2, 3'd2, 3'd2},
    {3'd4, 5'b00011, 3'd4, 3'd0, 3'd1, 3'd0, 3'd1},
    {3'd6, 5'b01000, 3'd6, 3'd3, 3'd3, 3'd3, 3'd3},
    {3'd1, 5'b00000, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1}
  };

  initial begin
    int s0;
    logic [31:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R11 power pins
    chk("R1 reset word", reg_rdata, 32'h0);
    chk("R11 reset power pins", {30'd0, conv_pwr, conv_tsens_pwr}, 32'h0);
    chk("R2 no start out of reset", {31'd0, conv_start}, 32'h0);

    // R8 and R9: scan table walked by one loop
    for (int e = 0; e < 6; e++) begin
      logic [22:0] t;
      t = RR_TAB[e];
      wr(mk(1, 0, 0, 0, 0, t[22:20], t[19:15]));
      for (int j = 0; j < 4; j++) begin
        logic [2:0] exp_ch;
        exp_ch = t[14 - 3*j -: 3];
        s0 = n_start;
        cur = reg_rdata;
        wr(cur | 32'h4);
        wait_idle();
        chk("R2 one start per trigger", n_start - s0, 1);
        chk((e >= 4) ? "R9 scan channel" : "R8 scan channel", {29'd0, last_chan}, {29'd0, exp_ch});
      end
      chk((e >= 4) ? "R9 selector read-back" : "R8 selector read-back",
          {29'd0, reg_rdata[14:12]}, {29'd0, t[2:0]});
      chk("R2 trigger bit reads 0", {31'd0, reg_rdata[2]}, 32'h0);
    end

    // R11 and R5: sensor power, ready when idle
    wr(mk(1, 1, 0, 0, 0, 0, 0));
    chk("R5 R11 idle word", reg_rdata, 32'h0000_0103);
    chk("R11 pins", {30'd0, conv_pwr, conv_tsens_pwr}, 32'h3);

    // R1 reserved and read-only bits
    wr(32'hFFE0_8FF0);
    chk("R1 reserved and ro bits", reg_rdata, 32'h0);
    chk("R10 power off", {31'd0, conv_pwr}, 32'h0);

    // R10 trigger dropped while disabled
    s0 = n_start;
    wr(mk(0, 0, 1, 0, 0, 0, 0));
    idle(20);
    chk("R10 no start when disabled", n_start - s0, 0);
    chk("R10 disabled word", reg_rdata, 32'h0);
    wr(mk(1, 0, 0, 0, 0, 0, 0));
    idle(20);
    chk("R10 dropped trigger not held", n_start - s0, 0);

    // R5 ready low during conversion
    wr(mk(1, 0, 1, 0, 0, 0, 0));
    @(negedge clk);
    chk("R5 ready low in flight", {31'd0, reg_rdata[8]}, 32'h0);
    wait_idle();
    chk("R5 ready back", {31'd0, reg_rdata[8]}, 32'h1);

    // R4 continuous mode
    s0 = n_start;
    n_b2b = 0;
    wr(mk(1, 0, 0, 1, 0, 2, 0));
    idle(60);
    begin
      int ns, nb;
      ns = n_start - s0; nb = n_b2b;
      chk("R4 several runs", {31'd0, ns >= 5}, 32'h1);
      chk("R4 start right after done", nb, ns - 1);
    end
    while (!conv_start) @(negedge clk);
    wr(mk(1, 0, 0, 0, 0, 2, 0));
    s0 = n_start;
    wait_idle();
    idle(20);
    chk("R4 stop after in-flight", n_start - s0, 0);
    chk("R4 idle after stop", {31'd0, reg_rdata[8]}, 32'h1);

    // R3 trigger ignored with run
    wr(mk(1, 0, 1, 1, 0, 0, 0));
    chk("R3 trigger bit discarded", {31'd0, reg_rdata[2]}, 32'h0);
    while (!conv_start) @(negedge clk);
    wr(mk(1, 0, 0, 0, 0, 0, 0));
    s0 = n_start;
    wait_idle();
    idle(20);
    chk("R3 no extra start", n_start - s0, 0);

    // R6 and R7 error flags
    err_mode = 1'b1;
    wr(mk(1, 0, 1, 0, 0, 0, 0));
    wait_idle();
    chk("R6 R7 error set", {30'd0, reg_rdata[10:9]}, 32'h3);
    err_mode = 1'b0;
    wr(mk(1, 0, 1, 0, 0, 0, 0));
    wait_idle();
    chk("R6 error follows last", {30'd0, reg_rdata[10:9]}, 32'h2);
    wr(mk(1, 0, 0, 0, 0, 0, 0));
    chk("R7 write 0 keeps sticky", {31'd0, reg_rdata[10]}, 32'h1);
    wr(mk(1, 0, 0, 0, 1, 0, 0));
    chk("R7 write 1 clears sticky", {31'd0, reg_rdata[10]}, 32'h0);

    // R7 set wins over clear in the same cycle
    err_mode = 1'b1;
    wr(mk(1, 0, 1, 0, 0, 0, 0));
    while (!conv_done) @(negedge clk);
    wr(mk(1, 0, 0, 0, 1, 0, 0));
    chk("R7 set beats clear", {31'd0, reg_rdata[10]}, 32'h1);
    wait_idle();

    // R10 disable mid-conversion
    wr(mk(1, 0, 0, 0, 1, 0, 0));
    wr(mk(1, 0, 1, 0, 0, 0, 0));
    @(negedge clk);
    wr(mk(0, 0, 0, 0, 0, 0, 0));
    chk("R10 pwr off mid-flight", {30'd0, conv_pwr, reg_rdata[8]}, 32'h0);
    s0 = n_start;
    while (!conv_done) @(negedge clk);
    idle(2);
    chk("R10 in-flight error lands", {31'd0, reg_rdata[9]}, 32'h1);
    idle(20);
    chk("R10 no restart", n_start - s0, 0);
    err_mode = 1'b0;

    finish_run();
  end
endmodule